// File: doc/BRIEF.md
# DDR SDRAM Command Bus Monitor

This block sits beside the command bus of a four-bank DDR SDRAM and samples it at every rising clock edge. It turns each cycle into one decoded command, using the clock-enable level from the previous edge and the current one. It keeps the open/closed state and open row of every bank, and it follows the device's low-power mode. When a command breaks one of the device's legality rules, the block reports an error code for that cycle.

The rules it enforces are these. Mode-register and refresh commands need every bank precharged. A mode-register write is followed by a two-cycle window in which only no-operation is accepted. A write with auto-precharge holds off reads and writes until its burst ends, and it then holds off re-activation of its bank for a programmable number of cycles. The power-down flavour is chosen from the bank state at the moment clock enable falls. A command that is flagged changes no bank state.

All outputs are registered. They describe the command sampled at the previous rising edge.

Top module: `ddrmon_top`

## Requirements
- R1: One cycle after each edge, `cmd_code` shows the decoded command. The encoding is 0 no-operation (chip select high, or chip select low with the three strobes high), 1 mode-register write (BA0 low), 2 extended mode-register write (BA0 high), 3 auto refresh, 4 self-refresh entry, 5 activate, 6 read, 7 read with auto-precharge, 8 write, 9 write with auto-precharge, 10 burst stop, 11 single-bank precharge, 12 all-bank precharge, 13 power-down entry, 14 exit from clock-enable low, and 15 clock enable held low. Strobe patterns {RAS#,CAS#,WE#} with CS# low: 000 mode write, 001 refresh, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge. Address bit 10 selects auto-precharge or all-bank.
- R2: An accepted activate sets bit BA of `bank_open`. It stores the row address in slice BA of `open_rows` (bits BA*ADDR_W upward).
- R3: A single-bank precharge closes bank BA. An all-bank precharge closes every bank regardless of BA. An accepted read with auto-precharge closes its bank at once.
- R4: `err_flag` is high and `err_code` is non-zero for exactly the cycle after the offending edge. A flagged command changes no bank state and no stored row.
- R5: Mode-register writes, auto refresh and self-refresh entry issued while any bank is open give error code 2.
- R6: Any command other than no-operation at either of the two edges after an accepted mode-register write gives error code 1. This code takes priority over every other code.
- R7: Activating an open bank gives code 3. Reading or writing a closed bank gives code 4.
- R8: After an accepted write with auto-precharge, a read or write at any of the next BL/2 edges gives code 5. The bank closes at the BL/2-th edge. An accepted burst stop during this burst ends it at that edge.
- R9: An activate to the bank closed by that burst end, within T_RP edges after it, gives code 6. Other banks are unaffected.
- R10: A mode-register write with BA0 low latches the burst length from A[2:0] (001=2, 010=4, 011=8; other values keep the old length). The extended register write never changes it. The burst length is 4 after reset.
- R11: Clock enable falling with no-operation enters power-down. `dev_mode` becomes 3 if any bank is open and 4 if all are idle. Clock enable rising leaves it, and `dev_mode` returns to 1 (some bank open) or 0 (all idle). Any other command at either transition gives code 7, and the transition still takes place.
- R12: Clock enable falling with the refresh pattern and all banks idle enters self refresh (`dev_mode` 2) until clock enable rises.
- R13: After reset, all banks are closed, `dev_mode` is 0, `cmd_code` is 0 and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| ba | input | 2 | Bank address |
| addr | input | ADDR_W | Address bus, bit AP_BIT is the auto-precharge / all-bank bit |
| cmd_code | output | 4 | Decoded command of the last edge |
| err_flag | output | 1 | Rule violation at the last edge |
| err_code | output | 3 | Violation kind, 0 when none |
| dev_mode | output | 3 | Device mode |
| bank_open | output | 4 | Per-bank open flags |
| open_rows | output | 4*ADDR_W | Open row of every bank |

## Verification
The interesting collision is the final edge of a write-with-auto-precharge burst landing on the same edge as a new command. The bench issues an activate to the bursting bank exactly on the burst's last edge, while the bank is still open. It expects the open-bank code, and it expects the bank to close after that edge anyway. It then checks that the activate on the following edge gets the precharge-wait code. A second case places a read on the last burst edge and a burst stop on it, and checks that the read is refused and that the stop closes the bank. The remaining cases cover a forbidden command at a power-down transition, where both the error and the mode change must appear in the same cycle.

// File: rtl/ddrmon_pkg.sv
package ddrmon_pkg;

    localparam int NUM_BANKS   = 4;
    localparam int BANK_W      = 2;
    localparam int HALF_W      = 3;   // burst length / 2, at most 4
    localparam int LOCK_CYCLES = 2;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_MRS  = 4'd1,
        CMD_EMRS = 4'd2,
        CMD_REF  = 4'd3,
        CMD_SREF = 4'd4,
        CMD_ACT  = 4'd5,
        CMD_RD   = 4'd6,
        CMD_RDA  = 4'd7,
        CMD_WR   = 4'd8,
        CMD_WRA  = 4'd9,
        CMD_BST  = 4'd10,
        CMD_PRE  = 4'd11,
        CMD_PREA = 4'd12,
        CMD_PDE  = 4'd13,
        CMD_CKEX = 4'd14,
        CMD_CKEL = 4'd15
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_LOCK     = 3'd1,
        ERR_NOT_IDLE = 3'd2,
        ERR_ACT_OPEN = 3'd3,
        ERR_CLOSED   = 3'd4,
        ERR_WAP_BUSY = 3'd5,
        ERR_TRP      = 3'd6,
        ERR_CKE_CMD  = 3'd7
    } err_e;

    typedef enum logic [2:0] {
        MODE_IDLE   = 3'd0,
        MODE_ACTIVE = 3'd1,
        MODE_SREF   = 3'd2,
        MODE_PD_ACT = 3'd3,
        MODE_PD_PRE = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        LP_NONE,
        LP_SREF,
        LP_PDA,
        LP_PDP
    } lp_e;

    typedef struct packed {
        cmd_e              cmd;
        logic              pins_nop;
        logic [BANK_W-1:0] bank;
    } dec_t;

    // Burst-length field to clock cycles per burst; 0 means "keep".
    function automatic logic [HALF_W-1:0] half_from_field(input logic [2:0] f);
        case (f)
            3'b001:  return 3'd1;
            3'b010:  return 3'd2;
            3'b011:  return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic needs_quiet(input cmd_e c);
        return !(c inside {CMD_NOP, CMD_PDE, CMD_CKEX, CMD_CKEL});
    endfunction

endpackage

// File: rtl/ddrmon_decode.sv
module ddrmon_decode
    import ddrmon_pkg::*;
(
    input  logic              prev_cke,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic              ap,
    output dec_t              dec
);

    logic [2:0] strobes;
    logic       quiet;

    assign strobes = {ras_n, cas_n, we_n};
    assign quiet   = cs_n || (strobes == 3'b111);

    always_comb begin
        dec.bank     = ba;
        dec.pins_nop = quiet;
        dec.cmd      = CMD_NOP;
        case ({prev_cke, cke})
            2'b11: begin
                if (!quiet) begin
                    case (strobes)
                        3'b000:  dec.cmd = ba[0] ? CMD_EMRS : CMD_MRS;
                        3'b001:  dec.cmd = CMD_REF;
                        3'b011:  dec.cmd = CMD_ACT;
                        3'b101:  dec.cmd = ap ? CMD_RDA : CMD_RD;
                        3'b100:  dec.cmd = ap ? CMD_WRA : CMD_WR;
                        3'b110:  dec.cmd = CMD_BST;
                        3'b010:  dec.cmd = ap ? CMD_PREA : CMD_PRE;
                        default: dec.cmd = CMD_NOP;
                    endcase
                end
            end
            2'b10:   dec.cmd = (!cs_n && strobes == 3'b001) ? CMD_SREF : CMD_PDE;
            2'b01:   dec.cmd = CMD_CKEX;
            default: dec.cmd = CMD_CKEL;
        endcase
    end

endmodule

// File: rtl/ddrmon_bank.sv
module ddrmon_bank #(
    parameter int ROW_W = 13,
    parameter int T_RP  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             close_i,
    input  logic             trp_start_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             trp_busy_o
);

    localparam int TRP_W = $clog2(T_RP + 1);

    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [TRP_W-1:0] trp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
            trp_q  <= '0;
        end else begin
            if (act_i) begin
                open_q <= 1'b1;
                row_q  <= row_i;
            end else if (close_i) begin
                open_q <= 1'b0;
            end
            if (trp_start_i)
                trp_q <= TRP_W'(T_RP);
            else if (trp_q != '0)
                trp_q <= trp_q - 1'b1;
        end
    end

    assign open_o     = open_q;
    assign row_o      = row_q;
    assign trp_busy_o = (trp_q != '0);

    a_r2_act_opens: assert property (@(posedge clk) disable iff (rst)
        act_i |=> (open_q && row_q == $past(row_i)));

    a_r9_trp_after_close: assert property (@(posedge clk) disable iff (rst)
        trp_start_i |=> (!open_q && trp_busy_o));

endmodule

// File: rtl/ddrmon_rules.sv
module ddrmon_rules
    import ddrmon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  dec_t                 dec,
    input  logic [2:0]           bl_field,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic [NUM_BANKS-1:0] trp_busy,
    output err_e                 err,
    output logic [NUM_BANKS-1:0] act_go,
    output logic [NUM_BANKS-1:0] close_go,
    output logic [NUM_BANKS-1:0] trp_go,
    output lp_e                  lp
);

    logic [1:0]        lock_q;
    logic [HALF_W-1:0] wap_q;
    logic [BANK_W-1:0] wap_bank_q;
    logic [HALF_W-1:0] half_q;
    lp_e               lp_q;

    logic any_open, wap_busy, sel_open, sel_trp, ok, wap_end;
    logic [HALF_W-1:0] new_half;

    assign any_open = |bank_open;
    assign wap_busy = (wap_q != '0);
    assign sel_open = bank_open[dec.bank];
    assign sel_trp  = trp_busy[dec.bank];
    assign new_half = half_from_field(bl_field);

    always_comb begin
        err = ERR_NONE;
        if (lock_q != '0 && needs_quiet(dec.cmd)) begin
            err = ERR_LOCK;
        end else begin
            case (dec.cmd)
                CMD_MRS, CMD_EMRS, CMD_REF, CMD_SREF:
                    if (any_open) err = ERR_NOT_IDLE;
                CMD_ACT:
                    if (sel_open)     err = ERR_ACT_OPEN;
                    else if (sel_trp) err = ERR_TRP;
                CMD_RD, CMD_RDA, CMD_WR, CMD_WRA:
                    if (wap_busy)      err = ERR_WAP_BUSY;
                    else if (!sel_open) err = ERR_CLOSED;
                CMD_PDE, CMD_CKEX:
                    if (!dec.pins_nop) err = ERR_CKE_CMD;
                default: err = ERR_NONE;
            endcase
        end
    end

    assign ok      = (err == ERR_NONE);
    assign wap_end = wap_busy && (wap_q == HALF_W'(1) || (dec.cmd == CMD_BST && ok));

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank_ctl
        logic hit;
        logic burst_hit;
        assign hit       = (dec.bank == BANK_W'(g));
        assign burst_hit = wap_end && (wap_bank_q == BANK_W'(g));
        assign act_go[g]   = ok && dec.cmd == CMD_ACT && hit;
        assign close_go[g] = burst_hit
                          || (ok && dec.cmd == CMD_PREA)
                          || (ok && hit && (dec.cmd == CMD_PRE || dec.cmd == CMD_RDA));
        assign trp_go[g]   = burst_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q     <= '0;
            wap_q      <= '0;
            wap_bank_q <= '0;
            half_q     <= HALF_W'(2);
            lp_q       <= LP_NONE;
        end else begin
            if (ok && (dec.cmd == CMD_MRS || dec.cmd == CMD_EMRS))
                lock_q <= 2'(LOCK_CYCLES);
            else if (lock_q != '0)
                lock_q <= lock_q - 1'b1;

            if (wap_end) begin
                wap_q <= '0;
            end else if (ok && dec.cmd == CMD_WRA) begin
                wap_q      <= half_q;
                wap_bank_q <= dec.bank;
            end else if (wap_busy) begin
                wap_q <= wap_q - 1'b1;
            end

            if (ok && dec.cmd == CMD_MRS && new_half != '0)
                half_q <= new_half;

            case (dec.cmd)
                CMD_SREF: if (ok) lp_q <= LP_SREF;
                CMD_PDE:  lp_q <= any_open ? LP_PDA : LP_PDP;
                CMD_CKEX: lp_q <= LP_NONE;
                default:  lp_q <= lp_q;
            endcase
        end
    end

    assign lp = lp_q;

    a_r6_lock_armed: assert property (@(posedge clk) disable iff (rst)
        (ok && (dec.cmd == CMD_MRS || dec.cmd == CMD_EMRS)) |=> (lock_q == 2'd2));

    a_r12_sref_banks_idle: assert property (@(posedge clk) disable iff (rst)
        (lp_q == LP_SREF) |-> !any_open);

    a_r8_burst_bounded: assert property (@(posedge clk) disable iff (rst)
        wap_q <= HALF_W'(4));

    a_r8_burst_blocks_rw: assert property (@(posedge clk) disable iff (rst)
        (wap_busy && dec.cmd inside {CMD_RD, CMD_RDA, CMD_WR, CMD_WRA}) |-> (|act_go == 1'b0 && !ok));

    a_r4_flag_no_open: assert property (@(posedge clk) disable iff (rst)
        !ok |-> (act_go == '0));

endmodule

// File: rtl/ddrmon_top.sv
module ddrmon_top
    import ddrmon_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10,
    parameter int T_RP   = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cke,
    input  logic                          cs_n,
    input  logic                          ras_n,
    input  logic                          cas_n,
    input  logic                          we_n,
    input  logic [1:0]                    ba,
    input  logic [ADDR_W-1:0]             addr,
    output logic [3:0]                    cmd_code,
    output logic                          err_flag,
    output logic [2:0]                    err_code,
    output logic [2:0]                    dev_mode,
    output logic [3:0]                    bank_open,
    output logic [4*ADDR_W-1:0]           open_rows
);

    localparam int ROW_W = ADDR_W;

    logic                 prev_cke_q;
    dec_t                 dec;
    err_e                 err;
    lp_e                  lp;
    logic [NUM_BANKS-1:0] act_go, close_go, trp_go, trp_busy, open_v;
    cmd_e                 cmd_q;
    err_e                 err_q;

    ddrmon_decode u_decode (
        .prev_cke (prev_cke_q),
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ba       (ba),
        .ap       (addr[AP_BIT]),
        .dec      (dec)
    );

    ddrmon_rules u_rules (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .bl_field  (addr[2:0]),
        .bank_open (open_v),
        .trp_busy  (trp_busy),
        .err       (err),
        .act_go    (act_go),
        .close_go  (close_go),
        .trp_go    (trp_go),
        .lp        (lp)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        ddrmon_bank #(.ROW_W(ROW_W), .T_RP(T_RP)) u_bank (
            .clk         (clk),
            .rst         (rst),
            .act_i       (act_go[g]),
            .row_i       (addr),
            .close_i     (close_go[g]),
            .trp_start_i (trp_go[g]),
            .open_o      (open_v[g]),
            .row_o       (open_rows[g*ROW_W +: ROW_W]),
            .trp_busy_o  (trp_busy[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_cke_q <= 1'b1;
            cmd_q      <= CMD_NOP;
            err_q      <= ERR_NONE;
        end else begin
            prev_cke_q <= cke;
            cmd_q      <= dec.cmd;
            err_q      <= err;
        end
    end

    always_comb begin
        case (lp)
            LP_SREF: dev_mode = MODE_SREF;
            LP_PDA:  dev_mode = MODE_PD_ACT;
            LP_PDP:  dev_mode = MODE_PD_PRE;
            default: dev_mode = (|open_v) ? MODE_ACTIVE : MODE_IDLE;
        endcase
    end

    assign cmd_code  = cmd_q;
    assign err_code  = err_q;
    assign err_flag  = (err_q != ERR_NONE);
    assign bank_open = open_v;

    a_r4_error_pulse: assert property (@(posedge clk) disable iff (rst)
        (err != ERR_NONE) |=> (err_flag && err_code == $past(err)));

    a_r11_pd_from_cke_fall: assert property (@(posedge clk) disable iff (rst)
        (prev_cke_q && !cke && dec.cmd == CMD_PDE) |=>
            (dev_mode == MODE_PD_ACT || dev_mode == MODE_PD_PRE));

endmodule

// File: tb/ddrmon_top_bench.sv
module ddrmon_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [3:0]  cmd_code;
    logic        err_flag;
    logic [2:0]  err_code;
    logic [2:0]  dev_mode;
    logic [3:0]  bank_open;
    logic [51:0] open_rows;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    localparam logic [3:0] P_DES = 4'b1111, P_NOP = 4'b0111, P_MRS = 4'b0000,
                           P_REF = 4'b0001, P_ACT = 4'b0011, P_RD  = 4'b0101,
                           P_WR  = 4'b0100, P_BST = 4'b0110, P_PRE = 4'b0010;
    localparam logic [12:0] AP = 13'h400;

    typedef struct {
        logic [3:0]  c;
        logic [2:0]  e;
        logic [2:0]  m;
        logic [3:0]  o;
        int          rb;
        logic [12:0] row;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    ddrmon_top u_ddrmon_top (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_code(cmd_code), .err_flag(err_flag), .err_code(err_code),
        .dev_mode(dev_mode), .bank_open(bank_open), .open_rows(open_rows)
    );

    task automatic drive(input logic k, input logic [3:0] p, input logic [1:0] b,
                         input logic [12:0] a, input logic [3:0] ec, input logic [2:0] ee,
                         input logic [2:0] em, input logic [3:0] eo, input string tag,
                         input int rb = -1, input logic [12:0] row = '0);
        exp_t x;
        @(negedge clk);
        cke = k; {cs_n, ras_n, cas_n, we_n} = p; ba = b; addr = a;
        x.c = ec; x.e = ee; x.m = em; x.o = eo; x.rb = rb; x.row = row; x.tag = tag;
        sb.push_back(x);
    endtask

    // Monitor: compare one expected item per edge, away from the edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t x;
            logic ok;
            x = sb.pop_front();
            ok = (cmd_code == x.c) && (err_code == x.e) && (err_flag == (x.e != 0))
              && (dev_mode == x.m) && (bank_open == x.o);
            if (x.rb >= 0) ok = ok && (open_rows[x.rb*13 +: 13] == x.row);
            tests++;
            if (!ok) begin
                fails++;
                $display("FAIL %s: got cmd=%0d err=%0d flag=%0d mode=%0d open=%b exp cmd=%0d err=%0d mode=%0d open=%b",
                         x.tag, cmd_code, err_code, err_flag, dev_mode, bank_open,
                         x.c, x.e, x.m, x.o);
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        tests++;
        if (cmd_code != 0 || err_flag || err_code != 0 || dev_mode != 0 || bank_open != 0) begin
            fails++;
            $display("FAIL R13 reset: got cmd=%0d err=%0d mode=%0d open=%b exp 0 0 0 0000",
                     cmd_code, err_code, dev_mode, bank_open);
        end
        //    cke pins  ba  addr        cmd err mode open
        drive(1, P_NOP, 0, 0,           0,  0, 0, 4'b0000, "R1 nop");
        drive(1, P_MRS, 0, 13'h003,     1,  0, 0, 4'b0000, "R10 mrs bl8");
        drive(1, P_ACT, 1, 13'h011,     5,  1, 0, 4'b0000, "R6 act in lock");
        drive(1, P_NOP, 0, 0,           0,  0, 0, 4'b0000, "R6 nop in lock");
        drive(1, P_REF, 0, 0,           3,  0, 0, 4'b0000, "R5 refresh idle");
        drive(1, P_ACT, 1, 13'h155,     5,  0, 1, 4'b0010, "R2 act bank1", 1, 13'h155);
        drive(1, P_ACT, 1, 13'h0F0,     5,  3, 1, 4'b0010, "R7 R4 act open", 1, 13'h155);
        drive(1, P_RD,  2, 0,           6,  4, 1, 4'b0010, "R7 read closed");
        drive(1, P_REF, 0, 0,           3,  2, 1, 4'b0010, "R5 refresh open");
        drive(1, P_MRS, 0, 13'h001,     1,  2, 1, 4'b0010, "R5 mrs open");
        drive(1, P_ACT, 3, 13'h0AA,     5,  0, 1, 4'b1010, "R2 act bank3", 3, 13'h0AA);
        drive(1, P_WR,  3, AP,          9,  0, 1, 4'b1010, "R8 wra bank3");
        drive(1, P_RD,  1, 0,           6,  5, 1, 4'b1010, "R8 read in burst");
        drive(1, P_NOP, 0, 0,           0,  0, 1, 4'b1010, "R8 nop in burst");
        drive(1, P_WR,  1, 0,           8,  5, 1, 4'b1010, "R8 write in burst");
        drive(1, P_ACT, 3, 13'h0AA,     5,  3, 1, 4'b0010, "R8 act on last burst edge");
        drive(1, P_ACT, 3, 13'h0AA,     5,  6, 1, 4'b0010, "R9 act within trp");
        drive(1, P_ACT, 2, 13'h007,     5,  0, 1, 4'b0110, "R9 other bank", 2, 13'h007);
        drive(1, P_ACT, 3, 13'h0BB,     5,  0, 1, 4'b1110, "R9 act after trp", 3, 13'h0BB);
        drive(1, P_RD,  1, 0,           6,  0, 1, 4'b1110, "R1 read ok");
        drive(1, P_RD,  2, AP,          7,  0, 1, 4'b1010, "R3 read autopre");
        drive(1, P_PRE, 1, 0,          11,  0, 1, 4'b1000, "R3 single pre");
        drive(0, P_NOP, 0, 0,          13,  0, 3, 4'b1000, "R11 pd active");
        drive(0, P_ACT, 0, 0,          15,  0, 3, 4'b1000, "R11 held low");
        drive(1, P_NOP, 0, 0,          14,  0, 1, 4'b1000, "R11 exit active");
        drive(1, P_PRE, 2, AP,         12,  0, 0, 4'b0000, "R3 precharge all");
        drive(0, P_ACT, 0, 0,          13,  7, 4, 4'b0000, "R11 pd entry bad cmd");
        drive(1, P_NOP, 0, 0,          14,  0, 0, 4'b0000, "R11 exit idle");
        drive(0, P_REF, 0, 0,           4,  0, 2, 4'b0000, "R12 self refresh");
        drive(0, P_NOP, 0, 0,          15,  0, 2, 4'b0000, "R12 stay");
        drive(1, P_RD,  0, 0,          14,  7, 0, 4'b0000, "R11 exit bad cmd");
        drive(1, P_MRS, 1, 13'h001,     2,  0, 0, 4'b0000, "R10 emrs");
        drive(1, P_NOP, 0, 0,           0,  0, 0, 4'b0000, "R6 nop");
        drive(1, P_DES, 0, 0,           0,  0, 0, 4'b0000, "R1 deselect");
        drive(1, P_ACT, 0, 13'h003,     5,  0, 1, 4'b0001, "R2 act bank0", 0, 13'h003);
        drive(1, P_WR,  0, AP,          9,  0, 1, 4'b0001, "R10 wra bl8 kept");
        drive(1, P_NOP, 0, 0,           0,  0, 1, 4'b0001, "R10 burst 1");
        drive(1, P_NOP, 0, 0,           0,  0, 1, 4'b0001, "R10 burst 2");
        drive(1, P_NOP, 0, 0,           0,  0, 1, 4'b0001, "R10 burst 3");
        drive(1, P_RD,  0, 0,           6,  5, 0, 4'b0000, "R10 R8 read on 4th edge");
        drive(1, P_MRS, 0, 13'h001,     1,  0, 0, 4'b0000, "R10 mrs bl2");
        drive(1, P_NOP, 0, 0,           0,  0, 0, 4'b0000, "R6 nop a");
        drive(1, P_NOP, 0, 0,           0,  0, 0, 4'b0000, "R6 nop b");
        drive(1, P_ACT, 0, 13'h009,     5,  0, 1, 4'b0001, "R2 act bank0 again", 0, 13'h009);
        drive(1, P_WR,  0, AP,          9,  0, 1, 4'b0001, "R10 wra bl2");
        drive(1, P_WR,  0, 0,           8,  5, 0, 4'b0000, "R8 write on last edge");
        drive(1, P_ACT, 0, 13'h009,     5,  6, 0, 4'b0000, "R9 trp bank0");
        drive(1, P_NOP, 0, 0,           0,  0, 0, 4'b0000, "R9 wait");
        drive(1, P_ACT, 0, 13'h00C,     5,  0, 1, 4'b0001, "R9 act ok", 0, 13'h00C);
        drive(1, P_WR,  0, AP,          9,  0, 1, 4'b0001, "R8 wra for stop");
        drive(1, P_BST, 0, 0,          10,  0, 0, 4'b0000, "R8 burst stop ends");
        drive(1, P_BST, 0, 0,          10,  0, 0, 4'b0000, "R8 burst stop idle");
        drive(1, P_NOP, 0, 0,           0,  0, 0, 4'b0000, "R1 final nop");
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule